// File: doc/BRIEF.md
# Synchronous Burst Static Memory Model

A cycle-accurate, synthesizable model of a clocked static memory with a two-lane data path (two 9-bit lanes, 18 bits by default). A bus master starts an access by pulling one of two address strobes low. One strobe is meant for a processor and one for a memory controller, and each is qualified by the three chip enables in its own way. After the load, a burst-advance input steps a 2-bit burst counter. The counter visits the four words of an aligned group in either interleaved or linear order, chosen by a static order pin.

Writes can cover the whole word or be steered per lane through a hierarchy of global, byte and lane enables. Read data is registered, so it comes out one clock after its address is loaded or stepped. An asynchronous output enable gates whether the model drives the bus. An asynchronous snooze input deselects the part and stops all activity while keeping the stored contents. The bus is modelled as split pins (`wdata`, `rdata`, `rdata_drive`), and `rdata_drive` low stands for high impedance. The storage is kept small so it can be simulated.

Top module: `sbsram_model`

## Requirements
- R1: When `strobe_ctl_n` is sampled low and all enables are active (`en_main_n` low, `en_hi` high, `en_lo_n` low), `addr` is loaded as the burst start and that word is accessed.
- R2: With `en_main_n` high, a low `strobe_cpu_n` is ignored. No address is loaded, and a selected burst keeps its current address.
- R3: A strobe that acts while any enable is inactive deselects the device. `rdata_drive` is low on the following cycle, and later advance pulses do not reselect it.
- R4: With no strobe acting and the device selected, `adv_n` low steps the burst count by one. `adv_n` high keeps the same word.
- R5: With `order_sel` high, the low two address bits of burst step k are (start low bits) XOR k.
- R6: With `order_sel` low, the low two address bits of burst step k are (start low bits + k) mod 4.
- R7: `gw_n` low on an access cycle writes `wdata` into both lanes of the addressed word.
- R8: With `gw_n` high and `bw_n` low, lane k is written only if `lane_we_n[k]` is low. Lane 0 is bits 8:0 and lane 1 is bits 17:9.
- R9: With `gw_n` high and either `bw_n` high or both `lane_we_n` bits high, the cycle is a read and the memory is unchanged.
- R10: `rdata_drive` is high only while `oe_n` is low and the last clock edge performed a selected read. `oe_n` takes effect without a clock edge.
- R11: While `snooze` is high, `rdata_drive` is low at once and every write is dropped, including one on the edge where snooze rises. The contents are kept, and the device comes back deselected.
- R12: If `strobe_cpu_n` loads an address (enables active), the cycle is a read whatever the write enables say. This also holds when `strobe_ctl_n` is low on the same edge, because the processor strobe has priority.
- R13: Read data for a loaded or stepped address is valid on `rdata` in the cycle after that clock edge, and back-to-back loads return back-to-back words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs sampled on its rising edge |
| snooze | input | 1 | Asynchronous low-power request, active high; also clears control state |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address |
| en_main_n | input | 1 | Primary chip enable, active low |
| en_hi | input | 1 | Secondary chip enable, active high |
| en_lo_n | input | 1 | Secondary chip enable, active low |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write enable, active low |
| bw_n | input | 1 | Lane write enable master, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_drive | output | 1 | High when the model drives the bus; low means high impedance |

## Verification
The bench builds the model with ADDR_W = 6 and leaves the lane and burst widths at their defaults. A 64-word array can then be filled and mirrored completely in the bench, so every read is compared against the expected word. With a 2-bit burst field, a full wrap in both orders is reached from non-zero start offsets. Two 9-bit lanes let single-lane writes be told apart from whole-word writes.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;

   localparam int MAX_BURST_W = 4;
endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
   import sbsram_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              snooze,
   input  logic              order_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic              en_main_n,
   input  logic              en_hi,
   input  logic              en_lo_n,
   input  logic              strobe_cpu_n,
   input  logic              strobe_ctl_n,
   input  logic              adv_n,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              access,
   output logic              cpu_load
);
   localparam int HI_W = ADDR_W - BURST_W;

   if (BURST_W < 1 || BURST_W > MAX_BURST_W || BURST_W >= ADDR_W) begin : g_bad_burst
      $error("sbsram_ctrl: BURST_W out of range");
   end

   logic              sel_q;
   logic [ADDR_W-1:0] base_q;
   logic [BURST_W-1:0] cnt_q;

   logic cpu_req, ctl_req, any_strobe, all_en, load, cont, step;
   logic [ADDR_W-1:0]  base_use;
   logic [BURST_W-1:0] cnt_use, off_lin, off_int, off;

   always_comb begin
      cpu_req    = !strobe_cpu_n && !en_main_n;
      ctl_req    = !strobe_ctl_n;
      any_strobe = cpu_req || ctl_req;
      all_en     = !en_main_n && en_hi && !en_lo_n;
      load       = any_strobe && all_en;
      cpu_load   = !snooze && cpu_req && all_en;
      cont       = !any_strobe && sel_q;
      step       = cont && !adv_n;
      access     = !snooze && (load || cont);
      base_use   = load ? addr : base_q;
      if (load)      cnt_use = '0;
      else if (step) cnt_use = cnt_q + 1'b1;
      else           cnt_use = cnt_q;
      off_lin    = base_use[BURST_W-1:0] + cnt_use;
      off_int    = base_use[BURST_W-1:0] ^ cnt_use;
      off        = (burst_order_e'(order_sel) == ORD_INTERLEAVE) ? off_int : off_lin;
      eff_addr   = {base_use[ADDR_W-1 -: HI_W], off};
   end

   always_ff @(posedge clk) begin
      if (snooze) begin
         sel_q  <= 1'b0;
         base_q <= '0;
         cnt_q  <= '0;
      end else if (any_strobe) begin
         sel_q <= all_en;
         if (all_en) begin
            base_q <= addr;
            cnt_q  <= '0;
         end
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R2: a blocked processor strobe loads nothing
   a_r2_cpu_blocked: assert property (@(posedge clk) disable iff (snooze)
      (en_main_n && !strobe_cpu_n && strobe_ctl_n) |=> $stable(base_q));

   // R4: advance steps the burst count
   a_r4_adv_step: assert property (@(posedge clk) disable iff (snooze)
      (sel_q && strobe_ctl_n && (strobe_cpu_n || en_main_n) && !adv_n)
      |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R3: a controller strobe with the high enable off deselects
   a_r3_deselect: assert property (@(posedge clk) disable iff (snooze)
      (!strobe_ctl_n && !en_hi) |=> !sel_q);
endmodule

// File: rtl/sbsram_wdec.sv
module sbsram_wdec #(
   parameter int LANES = 2
) (
   input  logic             gw_n,
   input  logic             bw_n,
   input  logic [LANES-1:0] lane_we_n,
   output logic [LANES-1:0] lane_mask,
   output logic             is_write
);
   if (LANES < 1) begin : g_bad_lanes
      $error("sbsram_wdec: LANES must be at least 1");
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lane_mask[k] = !gw_n || (!bw_n && !lane_we_n[k]);
   end

   assign is_write = |lane_mask;
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
   parameter int LANE_W = 9,
   parameter int LANES  = 2,
   parameter int ADDR_W = 10
) (
   input  logic                      clk,
   input  logic [ADDR_W-1:0]         eff_addr,
   input  logic [LANES-1:0]          lane_wr,
   input  logic                      rd_en,
   input  logic [LANES*LANE_W-1:0]   wdata,
   output logic [LANES*LANE_W-1:0]   rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_depth
      $error("sbsram_array: ADDR_W out of range");
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] q_q;

      always_ff @(posedge clk) begin
         if (lane_wr[k]) mem[eff_addr] <= wdata[k*LANE_W +: LANE_W];
         if (rd_en)      q_q <= mem[eff_addr];
      end

      assign rdata[k*LANE_W +: LANE_W] = q_q;
   end
endmodule

// File: rtl/sbsram_model.sv
module sbsram_model #(
   parameter int LANE_W  = 9,
   parameter int LANES   = 2,
   parameter int ADDR_W  = 10,
   parameter int BURST_W = 2
) (
   input  logic                    clk,
   input  logic                    snooze,
   input  logic                    order_sel,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    en_main_n,
   input  logic                    en_hi,
   input  logic                    en_lo_n,
   input  logic                    strobe_cpu_n,
   input  logic                    strobe_ctl_n,
   input  logic                    adv_n,
   input  logic                    gw_n,
   input  logic                    bw_n,
   input  logic [LANES-1:0]        lane_we_n,
   input  logic                    oe_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rdata_drive
);
   logic [ADDR_W-1:0] eff_addr;
   logic              access, cpu_load, is_write, rd_en, rd_q;
   logic [LANES-1:0]  lane_mask, lane_wr;

   sbsram_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctrl (
      .clk(clk), .snooze(snooze), .order_sel(order_sel), .addr(addr),
      .en_main_n(en_main_n), .en_hi(en_hi), .en_lo_n(en_lo_n),
      .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
      .eff_addr(eff_addr), .access(access), .cpu_load(cpu_load)
   );

   sbsram_wdec #(.LANES(LANES)) u_wdec (
      .gw_n(gw_n), .bw_n(bw_n), .lane_we_n(lane_we_n),
      .lane_mask(lane_mask), .is_write(is_write)
   );

   always_comb begin
      lane_wr = (access && !cpu_load) ? lane_mask : '0;
      rd_en   = access && (cpu_load || !is_write);
   end

   sbsram_array #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_array (
      .clk(clk), .eff_addr(eff_addr), .lane_wr(lane_wr), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata)
   );

   always_ff @(posedge clk) begin
      if (snooze) rd_q <= 1'b0;
      else        rd_q <= rd_en;
   end

   assign rdata_drive = !oe_n && rd_q && !snooze;

   // R11: no lane is written while snooze is high
   a_r11_snooze_no_write: assert property (@(posedge clk)
      snooze |-> (lane_wr == '0));

   // R12: a processor-strobe load never writes
   a_r12_cpu_load_reads: assert property (@(posedge clk) disable iff (snooze)
      cpu_load |-> (lane_wr == '0));

   // R7: after a global write the bus is not driven
   a_r7_write_no_drive: assert property (@(posedge clk) disable iff (snooze)
      (!gw_n && access && !cpu_load) |=> !rdata_drive);

   // R10: the bus is never driven while oe_n is high
   a_r10_oe_gates: assert property (@(posedge clk) disable iff (snooze)
      oe_n |-> !rdata_drive);
endmodule

// File: tb/sbsram_model_bench.sv
module sbsram_model_bench;
   localparam int PERIOD = 10;
   localparam int AW = 6;
   localparam int DW = 18;

   logic clk = 1'b0;
   logic snooze = 1'b1, order_sel = 1'b1;
   logic [AW-1:0] addr = '0;
   logic en_main_n = 1'b0, en_hi = 1'b1, en_lo_n = 1'b0;
   logic strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, adv_n = 1'b1;
   logic gw_n = 1'b1, bw_n = 1'b1;
   logic [1:0] lane_we_n = 2'b11;
   logic oe_n = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic rdata_drive;

   logic [DW-1:0] ref_mem [1<<AW];
   int n_cmp = 0, n_bad = 0;

   always #(PERIOD/2) clk = ~clk;

   sbsram_model #(.ADDR_W(AW)) u_sbsram_model (
      .clk(clk), .snooze(snooze), .order_sel(order_sel), .addr(addr),
      .en_main_n(en_main_n), .en_hi(en_hi), .en_lo_n(en_lo_n),
      .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
      .gw_n(gw_n), .bw_n(bw_n), .lane_we_n(lane_we_n), .oe_n(oe_n),
      .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1;
      gw_n = 1'b1; bw_n = 1'b1; lane_we_n = 2'b11;
      en_main_n = 1'b0; en_hi = 1'b1; en_lo_n = 1'b0;
   endtask

   task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
      idle(); addr = a; strobe_ctl_n = 1'b0; gw_n = 1'b0; wdata = d;
      tick(); ref_mem[a] = d; idle();
   endtask

   task automatic rd_expect(input logic [AW-1:0] a, input string req);
      idle(); addr = a; strobe_ctl_n = 1'b0;
      tick();
      chk(req, DW'(rdata_drive), DW'(1'b1));
      chk(req, rdata, ref_mem[a]);
      idle();
   endtask

   task automatic t_reset();
      tick(); tick();
      chk("R11 reset undriven", DW'(rdata_drive), '0);
      snooze = 1'b0; tick();
      chk("R11 wake deselected", DW'(rdata_drive), '0);
   endtask

   task automatic t_fill();
      for (int a = 0; a < (1<<AW); a++)
         wr_word(AW'(a), DW'((a * 1237 + 77) ^ (a << 9)));
      rd_expect(6'd0, "R7 R1 read 0");
      rd_expect(6'd45, "R7 R1 read 45");
      rd_expect(6'd63, "R7 R1 read 63");
   endtask

   task automatic t_pipe();
      idle(); addr = 6'd30; strobe_ctl_n = 1'b0; tick();
      chk("R13 first", rdata, ref_mem[30]);
      addr = 6'd31; tick();
      chk("R13 second", rdata, ref_mem[31]);
      addr = 6'd12; tick();
      chk("R13 third", rdata, ref_mem[12]);
      idle();
   endtask

   task automatic t_burst(input logic ord, input logic [AW-1:0] base, input string req);
      logic [1:0] off;
      order_sel = ord;
      idle(); addr = base; strobe_ctl_n = 1'b0; tick();
      chk(req, rdata, ref_mem[base]);
      idle(); adv_n = 1'b0;
      for (int k = 1; k < 4; k++) begin
         tick();
         off = ord ? (base[1:0] ^ 2'(k)) : (base[1:0] + 2'(k));
         chk(req, rdata, ref_mem[{base[AW-1:2], off}]);
      end
      adv_n = 1'b1; tick();
      chk("R4 suspend holds", rdata, ref_mem[{base[AW-1:2], off}]);
      idle(); order_sel = 1'b1;
   endtask

   task automatic t_burst_write();
      logic [DW-1:0] d;
      order_sel = 1'b0;
      idle(); addr = 6'd50; strobe_ctl_n = 1'b0; gw_n = 1'b0; wdata = 18'h11111;
      tick(); ref_mem[50] = 18'h11111;
      strobe_ctl_n = 1'b1; adv_n = 1'b0; wdata = 18'h22222;
      tick(); ref_mem[51] = 18'h22222;
      idle(); order_sel = 1'b1;
      rd_expect(6'd50, "R4 burst write start");
      rd_expect(6'd51, "R4 burst write step");
      d = ref_mem[51];
      chk("R4 burst write data", d, 18'h22222);
   endtask

   task automatic t_byte();
      idle(); addr = 6'd5; strobe_ctl_n = 1'b0; bw_n = 1'b0; lane_we_n = 2'b10;
      wdata = 18'h2ABCD; tick();
      ref_mem[5][8:0] = 9'h1CD;
      idle(); rd_expect(6'd5, "R8 lane0 only");
      addr = 6'd6; strobe_ctl_n = 1'b0; bw_n = 1'b0; lane_we_n = 2'b01;
      wdata = 18'h3F00F; tick();
      ref_mem[6][17:9] = 9'h1F8;
      idle(); rd_expect(6'd6, "R8 lane1 only");
   endtask

   task automatic t_readcycle();
      idle(); addr = 6'd10; strobe_ctl_n = 1'b0; bw_n = 1'b0; lane_we_n = 2'b11;
      wdata = ~ref_mem[10]; tick();
      chk("R9 lanes off is read", rdata, ref_mem[10]);
      idle(); addr = 6'd11; strobe_ctl_n = 1'b0; bw_n = 1'b1; lane_we_n = 2'b00;
      wdata = ~ref_mem[11]; tick();
      chk("R9 bw off is read", rdata, ref_mem[11]);
      idle();
      rd_expect(6'd10, "R9 unchanged 10");
      rd_expect(6'd11, "R9 unchanged 11");
   endtask

   task automatic t_cpu_blocked();
      rd_expect(6'd20, "R2 setup");
      en_main_n = 1'b1; strobe_cpu_n = 1'b0; addr = 6'd33; tick();
      chk("R2 blocked strobe", rdata, ref_mem[20]);
      chk("R2 still driven", DW'(rdata_drive), DW'(1'b1));
      idle();
   endtask

   task automatic t_deselect();
      idle(); addr = 6'd21; strobe_ctl_n = 1'b0; en_hi = 1'b0; tick();
      chk("R3 deselected", DW'(rdata_drive), '0);
      idle(); adv_n = 1'b0; tick();
      chk("R3 advance stays off", DW'(rdata_drive), '0);
      idle();
   endtask

   task automatic t_oe();
      rd_expect(6'd22, "R10 setup");
      oe_n = 1'b1; #1;
      chk("R10 async off", DW'(rdata_drive), '0);
      oe_n = 1'b0; #1;
      chk("R10 async on", DW'(rdata_drive), DW'(1'b1));
      tick();
   endtask

   task automatic t_priority();
      idle(); addr = 6'd9; strobe_cpu_n = 1'b0; strobe_ctl_n = 1'b0; gw_n = 1'b0;
      wdata = ~ref_mem[9]; tick();
      chk("R12 cpu load reads", rdata, ref_mem[9]);
      idle(); addr = 6'd8; strobe_cpu_n = 1'b0; gw_n = 1'b0; wdata = ~ref_mem[8]; tick();
      chk("R12 cpu load alone reads", rdata, ref_mem[8]);
      idle();
      rd_expect(6'd9, "R12 unchanged 9");
      rd_expect(6'd8, "R12 unchanged 8");
   endtask

   task automatic t_snooze();
      rd_expect(6'd40, "R11 setup");
      snooze = 1'b1; #1;
      chk("R11 async off", DW'(rdata_drive), '0);
      snooze = 1'b0; #1;
      chk("R11 async back", DW'(rdata_drive), DW'(1'b1));
      tick();
      idle(); addr = 6'd7; strobe_ctl_n = 1'b0; gw_n = 1'b0; wdata = ~ref_mem[7];
      snooze = 1'b1; tick();
      chk("R11 snoozing", DW'(rdata_drive), '0);
      addr = 6'd41; wdata = ~ref_mem[41]; tick(); tick();
      snooze = 1'b0; idle(); tick();
      chk("R11 wake deselected", DW'(rdata_drive), '0);
      rd_expect(6'd7, "R11 edge write dropped");
      rd_expect(6'd41, "R11 kept 41");
      rd_expect(6'd40, "R11 kept 40");
   endtask

   initial begin
      tick();
      t_reset();
      t_fill();
      t_pipe();
      t_burst(1'b1, 6'd18, "R5 interleaved");
      t_burst(1'b1, 6'd27, "R5 interleaved odd");
      t_burst(1'b0, 6'd35, "R6 linear");
      t_burst(1'b0, 6'd14, "R6 linear wrap");
      t_burst_write();
      t_byte();
      t_readcycle();
      t_cpu_blocked();
      t_deselect();
      t_oe();
      t_priority();
      t_snooze();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(PERIOD * 100000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule